// File: doc/BRIEF.md
# Sticky Interrupt Status Unit

This block collects one-cycle event pulses from a transmit FIFO, a receive FIFO and a descriptor-driven transfer engine. It also derives two level events by comparing the FIFO fill levels against programmable thresholds. Each event is captured in a status bit that stays set until software clears it. A single interrupt line is formed from the captured bits.

Gating happens in two places. A latch-enable register decides which events may set their status bit at all. A separate line-enable register decides which of the captured bits may drive the interrupt output. Software reaches the four registers through a plain word-addressed write port with a combinational read path. The status register is cleared by writing ones.

A controller soft-reset request empties both FIFOs. It therefore shows up as the transmit-empty and receive-empty events.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, all four registers read as zero and `irq_o` is low.
- R2: Each event sets its own status bit. The bits are transmit empty 0, transmit full 1, transmit threshold 2, receive empty 3, receive full 4, receive threshold 5, descriptor done 9, packet complete 10 and transfer error 11.
- R3: A status bit stays set after its event has gone away.
- R4: An event sets its status bit only in a cycle where the matching latch-enable bit is set. A disabled event leaves the status unchanged.
- R5: Writing the status register (address 0) clears every bit written as 1 and leaves the bits written as 0 unchanged.
- R6: If an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly when some bit is set in the status, the latch-enable register (address 1) and the line-enable register (address 2), all three at the same position.
- R8: The threshold register (address 3) holds the transmit threshold in bits 12:8 and the receive threshold in bits 4:0. All its other bits read as zero.
- R9: The transmit-threshold event is active while `tx_level` is less than or equal to the transmit threshold.
- R10: The receive-threshold event is active while `rx_level` is greater than or equal to the receive threshold.
- R11: A pulse on `soft_rst_req` raises both the transmit-empty and the receive-empty events.
- R12: Status, latch-enable and line-enable bits 6, 7, 8 and bits 12 and up always read as zero, whatever is written to them.
- R13: The read port returns the register chosen by `reg_addr` in the same cycle: 0 status, 1 latch enable, 2 line enable, 3 thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| ev_tx_empty | input | 1 | Transmit FIFO became empty |
| ev_tx_full | input | 1 | Transmit FIFO became full |
| ev_rx_empty | input | 1 | Receive FIFO became empty |
| ev_rx_full | input | 1 | Receive FIFO became full |
| ev_desc_done | input | 1 | One descriptor finished |
| ev_pkt_done | input | 1 | Whole packet finished |
| ev_xfer_err | input | 1 | Transfer engine error |
| soft_rst_req | input | 1 | Controller soft-reset request |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that a write to the status register and a raw event are both decided by values settled before the clock edge. They also assume that the level inputs stay stable within a cycle. The stimulus meets this by changing every input on the falling edge and by holding each pulse for exactly one cycle.

The threshold checks rely on the threshold values being programmed before the latch enables open. This keeps the receive-threshold event from latching on the reset value of zero. The stimulus programs the thresholds first and moves each FIFO level only between reads.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W     = 12;
  localparam int THR_W      = 5;
  localparam int ADDR_W     = 2;
  localparam int TX_THR_LSB = 8;
  localparam int RX_THR_LSB = 0;

  localparam int B_TXE = 0;
  localparam int B_TXF = 1;
  localparam int B_TXT = 2;
  localparam int B_RXE = 3;
  localparam int B_RXF = 4;
  localparam int B_RXT = 5;
  localparam int B_DSC = 9;
  localparam int B_PKT = 10;
  localparam int B_ERR = 11;

  typedef logic [STAT_W-1:0] stat_vec_t;

  localparam stat_vec_t LIVE_MASK = stat_vec_t'((1 << B_TXE) | (1 << B_TXF) | (1 << B_TXT) |
                                                (1 << B_RXE) | (1 << B_RXF) | (1 << B_RXT) |
                                                (1 << B_DSC) | (1 << B_PKT) | (1 << B_ERR));

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT    = 2'd0,
    SEL_LATCHEN = 2'd1,
    SEL_LINEEN  = 2'd2,
    SEL_THR     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int LVL_W = 6,
  parameter int THR_W = 5,
  parameter bit ABOVE = 1'b0
) (
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  function automatic logic at_or_below(input logic [LVL_W-1:0] l, input logic [THR_W-1:0] t);
    return CMP_W'(l) <= CMP_W'(t);
  endfunction

  function automatic logic at_or_above(input logic [LVL_W-1:0] l, input logic [THR_W-1:0] t);
    return CMP_W'(l) >= CMP_W'(t);
  endfunction

  generate
    if (ABOVE) begin : g_above
      assign hit = at_or_above(level, thr);
    end else begin : g_below
      assign hit = at_or_below(level, thr);
    end
  endgenerate
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output stat_vec_t         latch_en_q,
  output stat_vec_t         line_en_q,
  output logic [THR_W-1:0]  tx_thr_q,
  output logic [THR_W-1:0]  rx_thr_q
);
  stat_vec_t wmask;
  assign wmask = wdata[STAT_W-1:0] & LIVE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_en_q <= '0;
      line_en_q  <= '0;
      tx_thr_q   <= '0;
      rx_thr_q   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_LATCHEN: latch_en_q <= wmask;
        SEL_LINEEN:  line_en_q  <= wmask;
        SEL_THR: begin
          tx_thr_q <= wdata[TX_THR_LSB +: THR_W];
          rx_thr_q <= wdata[RX_THR_LSB +: THR_W];
        end
        default: ;
      endcase
    end
  end

  // R12: masked enables never hold a reserved bit
  p_en_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_en_q | line_en_q) & ~LIVE_MASK) == '0);
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
  import irq_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stat_vec_t ev_vec,
  input  stat_vec_t latch_en,
  input  stat_vec_t clr_mask,
  output stat_vec_t stat_q
);
  stat_vec_t gated_ev;
  assign gated_ev = ev_vec & latch_en & LIVE_MASK;

  genvar i;
  generate
    for (i = 0; i < STAT_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             stat_q[i] <= 1'b0;
        else if (gated_ev[i])   stat_q[i] <= 1'b1;
        else if (clr_mask[i])   stat_q[i] <= 1'b0;
      end
    end
  endgenerate

  // R3: set bits with no clear request stay set
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask)));
  // R4: a bit may only rise where its latch enable was set
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(latch_en)) == '0));
  // R6: an enabled event always leaves its bit set, even against a clear
  p_ev_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_vec & latch_en & LIVE_MASK) & ~stat_q) == '0));
  // R5: a clear with no competing event empties the bit
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_mask & ~(ev_vec & latch_en))) == '0));
  // R12: reserved status bits stay zero
  p_stat_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~LIVE_MASK) == '0);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_full,
  input  logic              ev_rx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_desc_done,
  input  logic              ev_pkt_done,
  input  logic              ev_xfer_err,
  input  logic              soft_rst_req,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              irq_o
);
  reg_sel_e         sel;
  stat_vec_t        latch_en_q, line_en_q, stat_q, ev_vec, clr_mask, armed;
  logic [THR_W-1:0] tx_thr_q, rx_thr_q;
  logic             tx_thr_hit, rx_thr_hit;
  logic             unused_wdata_hi;

  assign sel             = reg_sel_e'(reg_addr);
  assign unused_wdata_hi = ^reg_wdata;

  irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .sel        (sel),
    .wdata      (reg_wdata),
    .latch_en_q (latch_en_q),
    .line_en_q  (line_en_q),
    .tx_thr_q   (tx_thr_q),
    .rx_thr_q   (rx_thr_q)
  );

  irq_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b0)) u_tx_cmp (
    .level (tx_level),
    .thr   (tx_thr_q),
    .hit   (tx_thr_hit)
  );

  irq_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rx_cmp (
    .level (rx_level),
    .thr   (rx_thr_q),
    .hit   (rx_thr_hit)
  );

  always_comb begin
    ev_vec        = '0;
    ev_vec[B_TXE] = ev_tx_empty | soft_rst_req;
    ev_vec[B_TXF] = ev_tx_full;
    ev_vec[B_TXT] = tx_thr_hit;
    ev_vec[B_RXE] = ev_rx_empty | soft_rst_req;
    ev_vec[B_RXF] = ev_rx_full;
    ev_vec[B_RXT] = rx_thr_hit;
    ev_vec[B_DSC] = ev_desc_done;
    ev_vec[B_PKT] = ev_pkt_done;
    ev_vec[B_ERR] = ev_xfer_err;
  end

  assign clr_mask = (reg_wr && sel == SEL_STAT) ? (reg_wdata[STAT_W-1:0] & LIVE_MASK) : '0;

  irq_sticky_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_vec   (ev_vec),
    .latch_en (latch_en_q),
    .clr_mask (clr_mask),
    .stat_q   (stat_q)
  );

  assign armed = stat_q & latch_en_q & line_en_q;
  assign irq_o = |armed;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_STAT:    reg_rdata = DATA_W'(stat_q);
      SEL_LATCHEN: reg_rdata = DATA_W'(latch_en_q);
      SEL_LINEEN:  reg_rdata = DATA_W'(line_en_q);
      SEL_THR: begin
        reg_rdata[TX_THR_LSB +: THR_W] = tx_thr_q;
        reg_rdata[RX_THR_LSB +: THR_W] = rx_thr_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R7: the line is only raised with some status bit pending
  p_irq_needs_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_q != '0));
  // R9: an empty transmit FIFO always meets its threshold
  p_tx_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0 && latch_en_q[B_TXT]) |=> stat_q[B_TXT]);
  // R10: a zero receive threshold is always met
  p_rx_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr_q == '0 && latch_en_q[B_RXT]) |=> stat_q[B_RXT]);
  // R11: a soft-reset request raises both empty bits when enabled
  p_srst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_req && latch_en_q[B_TXE] && latch_en_q[B_RXE]) |=> (stat_q[B_TXE] && stat_q[B_RXE]));
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic ev_tx_empty = 0, ev_tx_full = 0, ev_rx_empty = 0, ev_rx_full = 0;
  logic ev_desc_done = 0, ev_pkt_done = 0, ev_xfer_err = 0, soft_rst_req = 0;
  logic [LVL_W-1:0]  tx_level = 6'd5;
  logic [LVL_W-1:0]  rx_level = 6'd0;
  logic              irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_status_unit #(.DATA_W(DATA_W), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_tx_empty(ev_tx_empty), .ev_tx_full(ev_tx_full),
    .ev_rx_empty(ev_rx_empty), .ev_rx_full(ev_rx_full),
    .ev_desc_done(ev_desc_done), .ev_pkt_done(ev_pkt_done),
    .ev_xfer_err(ev_xfer_err), .soft_rst_req(soft_rst_req),
    .tx_level(tx_level), .rx_level(rx_level), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb_q.push_back('{1'b0, e, tag});
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(negedge clk);
    sb_q.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_tx_empty  = 1'b1;
      1: ev_tx_full   = 1'b1;
      3: ev_rx_empty  = 1'b1;
      4: ev_rx_full   = 1'b1;
      9: ev_desc_done = 1'b1;
      10: ev_pkt_done = 1'b1;
      11: ev_xfer_err = 1'b1;
      default: soft_rst_req = 1'b1;
    endcase
    @(negedge clk);
    {ev_tx_empty, ev_tx_full, ev_rx_empty, ev_rx_full} = '0;
    {ev_desc_done, ev_pkt_done, ev_xfer_err, soft_rst_req} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R13: reset values on every address
    exp_rd(2'd0, 32'h0, "R1 status");
    exp_rd(2'd1, 32'h0, "R1 latch enable");
    exp_rd(2'd2, 32'h0, "R1 line enable");
    exp_rd(2'd3, 32'h0, "R1 R13 thresholds");
    exp_irq(1'b0, "R1 irq");
    // R4: disabled event is dropped
    pulse(11);
    exp_rd(2'd0, 32'h0, "R4 disabled event");
    // R8: thresholds tx=0 rx=31
    wr(2'd3, 32'h0000_001F);
    exp_rd(2'd3, 32'h0000_001F, "R8 threshold readback");
    // R12: reserved enable bits ignored
    wr(2'd1, 32'hFFFF_FFFF);
    exp_rd(2'd1, 32'h0000_0E3F, "R12 latch enable mask");
    exp_rd(2'd0, 32'h0, "R4 no events pending");
    // R2 / R3: cumulative sticky bits
    pulse(1);  exp_rd(2'd0, 32'h002, "R2 R3 tx full");
    pulse(9);  exp_rd(2'd0, 32'h202, "R2 desc done");
    pulse(10); exp_rd(2'd0, 32'h602, "R2 pkt done");
    pulse(11); exp_rd(2'd0, 32'hE02, "R2 xfer err");
    pulse(0);  exp_rd(2'd0, 32'hE03, "R2 tx empty");
    pulse(3);  exp_rd(2'd0, 32'hE0B, "R2 rx empty");
    pulse(4);  exp_rd(2'd0, 32'hE1B, "R2 R3 rx full");
    // R7: line gating
    exp_irq(1'b0, "R7 line enable off");
    wr(2'd2, 32'h0000_0800);
    exp_rd(2'd2, 32'h800, "R13 line enable readback");
    exp_irq(1'b1, "R7 error armed");
    // R5: write-one-to-clear
    wr(2'd0, 32'h0000_0800);
    exp_rd(2'd0, 32'h61B, "R5 clear bit 11");
    exp_irq(1'b0, "R7 cleared");
    wr(2'd0, 32'h0);
    exp_rd(2'd0, 32'h61B, "R5 zero write keeps");
    // R6: event and clear together
    @(negedge clk);
    ev_xfer_err = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h800;
    @(negedge clk);
    ev_xfer_err = 1'b0; reg_wr = 1'b0;
    exp_rd(2'd0, 32'hE1B, "R6 event wins");
    exp_irq(1'b1, "R7 armed again");
    wr(2'd0, 32'h0000_0FFF);
    exp_rd(2'd0, 32'h0, "R5 clear all");
    // R9: tx threshold
    wr(2'd3, 32'h0000_0505);
    exp_rd(2'd0, 32'h004, "R9 level equal threshold");
    @(negedge clk); tx_level = 6'd6;
    wr(2'd0, 32'h0000_0FFF);
    exp_rd(2'd0, 32'h0, "R9 above threshold");
    @(negedge clk); tx_level = 6'd4;
    exp_rd(2'd0, 32'h004, "R9 below threshold");
    @(negedge clk); tx_level = 6'd40;
    wr(2'd0, 32'h0000_0FFF);
    exp_rd(2'd0, 32'h0, "R9 wide level");
    // R10: rx threshold
    @(negedge clk); rx_level = 6'd4;
    exp_rd(2'd0, 32'h0, "R10 below threshold");
    @(negedge clk); rx_level = 6'd5;
    exp_rd(2'd0, 32'h020, "R10 at threshold");
    @(negedge clk); rx_level = 6'd0;
    wr(2'd0, 32'h0000_0FFF);
    exp_rd(2'd0, 32'h0, "R10 cleared");
    // R11: soft reset request
    pulse(99);
    exp_rd(2'd0, 32'h009, "R11 soft reset");
    wr(2'd0, 32'h0000_0FFF);
    // R4: partial enable
    wr(2'd1, 32'h0000_0004);
    pulse(11);
    exp_rd(2'd0, 32'h0, "R4 partial enable");
    // R8: full-width write
    wr(2'd3, 32'hFFFF_FFFF);
    exp_rd(2'd3, 32'h0000_1F1F, "R8 reserved bits zero");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hang expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule